// File: doc/BRIEF.md
# Host Mailbox Console Controller

This block is a memory-mapped mailbox through which a processor exchanges requests with a host. It has two 64-bit registers. The processor posts commands in the outbound register, called tohost. The block posts responses and console input in the inbound register, called fromhost. A 32-bit bus reaches each register as a low word at its base offset and a high word at the base offset plus 4. Both base offsets are parameters.

The processor writes a command in two steps. It writes the low word, which is accepted only while tohost is entirely zero. It then writes the high word, which completes the command and starts its execution in the same clock edge. Every command word carries three fields: a device number, a command code and a payload.

The block acts on the commands it recognises:
- Device 0, command 0, with payload bit 0 set, raises an exit request.
- Device 1, command 1 sends one console byte.
- Device 1, command 0 parks a console read request. The next byte that arrives on the console input is then merged into fromhost.

The console streams carry only a per-byte valid. There is no back-pressure in either direction. The consumer of `cout_*` must accept a byte in every cycle that `cout_valid` is high. A byte on `cin_*` is taken in every cycle that `cin_valid` is high, and it may overwrite a response that has not yet been read.

Top module: `hml_mailbox`

## Requirements
- R1: After reset, all four register words read zero, and `cout_valid` and `exit_req` are low.
- R2: The tohost low word is at `TO_OFS`, the tohost high word at `TO_OFS+4`, the fromhost low word at `FH_OFS` and the fromhost high word at `FH_OFS+4`. A read returns the matching 32-bit half. Any other address reads zero, and a write to it changes nothing.
- R3: A write to the tohost low word loads bits 31:0 and sets an allow flag, but only while the whole of tohost is zero. Otherwise the write is dropped and the allow flag is cleared, so that a following high-word write is also dropped.
- R4: A high-word write to tohost while the allow flag is set ORs the data into bits 63:32 and executes the resulting 64-bit command. After that edge, tohost reads zero.
- R5: The command fields are the device number in bits 63:56, the command code in bits 55:48 and the payload in bits 47:0. A command that writes fromhost loads bits 63:48 of the command into fromhost 63:48 and the 48-bit response into fromhost 47:0.
- R6: Device 0, command 0 with payload bit 0 set pulses `exit_req` for exactly one cycle, with `exit_code` equal to payload bits 8:1. The response is zero.
- R7: Device 0, command 0 with payload bit 0 clear raises no exit. The response is zero.
- R8: Device 1, command 1 pulses `cout_valid` for one cycle, with `cout_data` equal to payload bits 7:0. The response is 0x100 ORed with that byte.
- R9: Device 1, command 0 stores the command as the pending read request and clears tohost. Fromhost is left unchanged.
- R10: A cycle with `cin_valid` high loads fromhost with the pending request's bits 63:48 in bits 63:48 and with 0x100 ORed with `cin_data` in bits 47:0.
- R11: Any other device or command code gives a response of zero. Bits 63:48 of the command are still copied into fromhost.
- R12: A write to the fromhost low word replaces the whole of fromhost with the data zero-extended. A write to the fromhost high word ORs the data into bits 63:32.
- R13: When a bus write to fromhost, or an executed command that writes fromhost, falls in the same cycle as `cin_valid`, the input byte is dropped. The pending request used by an input byte is the one held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cin_valid | input | 1 | Console input byte valid (always accepted) |
| cin_data | input | 8 | Console input byte |
| cout_valid | output | 1 | Console output byte valid, one-cycle pulse |
| cout_data | output | 8 | Console output byte |
| exit_req | output | 1 | Exit request, one-cycle pulse |
| exit_code | output | 8 | Exit code, valid with `exit_req` |

## Verification
The bench targets the following corner cases, each paired with the failure it exposes:
- A second low-word write while tohost is still busy. A design without the busy gate would overwrite a command that has not yet been consumed.
- A high-word write after a rejected low write. A design with a stale allow flag would execute a half-written command.
- A console read followed by input bytes. A design that answered the read at once, or that merged the wrong header bits, would show a wrong fromhost value.
- Input bytes that collide with bus writes or executed commands in the same cycle. Any other priority shows up as a corrupted fromhost.
- Exit codes whose value depends on payload bit 8. A design that shifted the payload wrongly would report a wrong exit code.

// File: rtl/hml_pkg.sv
package hml_pkg;
  localparam int BUS_W  = 32;
  localparam int REG_W  = 64;
  localparam int HDR_W  = 16;   // device + command, bits 63:48
  localparam int RESP_W = 48;   // response / payload width
  localparam int BYTE_W = 8;

  // Slot order inside the address decoder
  localparam int SLOT_TO_LO = 0;
  localparam int SLOT_TO_HI = 1;
  localparam int SLOT_FH_LO = 2;
  localparam int SLOT_FH_HI = 3;
  localparam int N_SLOTS    = 4;

  localparam logic [7:0] DEV_SYS   = 8'h00;
  localparam logic [7:0] DEV_CONS  = 8'h01;
  localparam logic [7:0] CODE_ZERO = 8'h00;
  localparam logic [7:0] CODE_ONE  = 8'h01;
  localparam logic [7:0] RESP_TAG  = 8'h01;  // forms 0x100 | byte

  typedef struct packed {
    logic              load_fh;
    logic [REG_W-1:0]  fh_val;
    logic              store_pend;
    logic              putc;
    logic [BYTE_W-1:0] putc_byte;
    logic              do_exit;
    logic [BYTE_W-1:0] exit_code;
  } hml_action_t;
endpackage

// File: rtl/hml_addr_dec.sv
module hml_addr_dec
  import hml_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned TO_OFS = 0,
  parameter int unsigned FH_OFS = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [N_SLOTS-1:0] sel
);
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    localparam int unsigned BASE = (i < 2) ? TO_OFS : FH_OFS;
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(BASE + 4 * (i % 2));
    assign sel[i] = (addr == MATCH);
  end
endmodule

// File: rtl/hml_cmd_exec.sv
module hml_cmd_exec
  import hml_pkg::*;
(
  input  logic [HDR_W-1:0] cmd_hdr,   // bits 63:48 of the command
  input  logic [8:0]       cmd_low,   // payload bits 8:0
  output hml_action_t      act
);
  logic [7:0]        dev;
  logic [7:0]        code;
  logic [RESP_W-1:0] resp;

  assign dev  = cmd_hdr[15:8];
  assign code = cmd_hdr[7:0];

  always_comb begin
    act  = '0;
    resp = '0;
    act.load_fh = 1'b1;
    if (dev == DEV_SYS && code == CODE_ZERO) begin
      act.do_exit   = cmd_low[0];
      act.exit_code = cmd_low[8:1];
    end else if (dev == DEV_CONS && code == CODE_ONE) begin
      act.putc      = 1'b1;
      act.putc_byte = cmd_low[7:0];
      resp          = {{(RESP_W-16){1'b0}}, RESP_TAG, cmd_low[7:0]};
    end else if (dev == DEV_CONS && code == CODE_ZERO) begin
      act.load_fh    = 1'b0;
      act.store_pend = 1'b1;
    end
    act.fh_val = {cmd_hdr, resp};
  end
endmodule

// File: rtl/hml_regs.sv
module hml_regs
  import hml_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [N_SLOTS-1:0] sel,
  input  logic [BUS_W-1:0]   wdata,
  input  hml_action_t        act,
  input  logic               cin_valid,
  input  logic [BYTE_W-1:0]  cin_data,
  output logic [REG_W-1:0]   cmd_word,
  output logic [REG_W-1:0]   tohost,
  output logic [REG_W-1:0]   fromhost,
  output logic               cout_valid,
  output logic [BYTE_W-1:0]  cout_data,
  output logic               exit_req,
  output logic [BYTE_W-1:0]  exit_code
);
  logic             allow;
  logic             inprog;
  logic [HDR_W-1:0] pend_hdr;
  logic             fire, fh_bus, fh_cmd;

  assign cmd_word = tohost | {wdata, {BUS_W{1'b0}}};
  assign fire     = wr_en & sel[SLOT_TO_HI] & allow;
  assign fh_bus   = wr_en & (sel[SLOT_FH_LO] | sel[SLOT_FH_HI]);
  assign fh_cmd   = fire & act.load_fh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tohost     <= '0;
      fromhost   <= '0;
      allow      <= 1'b0;
      inprog     <= 1'b0;
      pend_hdr   <= '0;
      cout_valid <= 1'b0;
      cout_data  <= '0;
      exit_req   <= 1'b0;
      exit_code  <= '0;
    end else begin
      cout_valid <= fire & act.putc;
      exit_req   <= fire & act.do_exit;
      if (fire && act.putc)    cout_data <= act.putc_byte;
      if (fire && act.do_exit) exit_code <= act.exit_code;

      if (wr_en && sel[SLOT_TO_LO]) begin
        if (tohost == '0) begin
          tohost <= {{BUS_W{1'b0}}, wdata};
          allow  <= 1'b1;
        end else begin
          allow  <= 1'b0;
        end
      end
      if (fire) begin
        tohost <= '0;
        if (act.store_pend) pend_hdr <= cmd_word[REG_W-1 -: HDR_W];
      end

      if (wr_en && sel[SLOT_FH_LO]) begin
        fromhost <= {{BUS_W{1'b0}}, wdata};
        inprog   <= 1'b1;
      end else if (wr_en && sel[SLOT_FH_HI]) begin
        fromhost <= fromhost | {wdata, {BUS_W{1'b0}}};
        inprog   <= 1'b0;
      end else if (fh_cmd) begin
        fromhost <= act.fh_val;
      end else if (cin_valid) begin
        fromhost <= {pend_hdr, {(RESP_W-16){1'b0}}, RESP_TAG, cin_data};
      end
    end
  end

  // R3
  reject_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel[SLOT_TO_LO] && tohost != '0) |=> $stable(tohost));
  // R4
  consume_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (tohost == '0));
  // R6
  exit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> !exit_req);
  // R8
  putc_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cout_valid |-> (fromhost[15:0] == {RESP_TAG, cout_data}));
  // R12
  inprog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel[SLOT_FH_LO]) |=> (inprog && fromhost[REG_W-1:BUS_W] == '0));
  // R10
  cin_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cin_valid && !fh_bus && !fh_cmd) |=>
      (fromhost[15:0] == {RESP_TAG, $past(cin_data)}));
endmodule

// File: rtl/hml_mailbox.sv
module hml_mailbox
  import hml_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned TO_OFS = 0,
  parameter int unsigned FH_OFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cin_valid,
  input  logic [7:0]        cin_data,
  output logic              cout_valid,
  output logic [7:0]        cout_data,
  output logic              exit_req,
  output logic [7:0]        exit_code
);
  logic [N_SLOTS-1:0] sel;
  logic [REG_W-1:0]   cmd_word, tohost, fromhost;
  hml_action_t        act;

  hml_addr_dec #(.ADDR_W(ADDR_W), .TO_OFS(TO_OFS), .FH_OFS(FH_OFS)) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  hml_cmd_exec u_exec (
    .cmd_hdr(cmd_word[REG_W-1 -: HDR_W]),
    .cmd_low(cmd_word[8:0]),
    .act    (act)
  );

  hml_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .sel(sel), .wdata(bus_wdata),
    .act(act), .cin_valid(cin_valid), .cin_data(cin_data),
    .cmd_word(cmd_word), .tohost(tohost), .fromhost(fromhost),
    .cout_valid(cout_valid), .cout_data(cout_data),
    .exit_req(exit_req), .exit_code(exit_code)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel[SLOT_TO_LO]) bus_rdata = tohost[BUS_W-1:0];
    if (sel[SLOT_TO_HI]) bus_rdata = tohost[REG_W-1:BUS_W];
    if (sel[SLOT_FH_LO]) bus_rdata = fromhost[BUS_W-1:0];
    if (sel[SLOT_FH_HI]) bus_rdata = fromhost[REG_W-1:BUS_W];
  end
endmodule

// File: tb/hml_mailbox_tb.sv
module hml_mailbox_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] TO_LO = 12'h040, TO_HI = 12'h044;
  localparam logic [11:0] FH_LO = 12'h020, FH_HI = 12'h024;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr_en = 1'b0, cin_valid = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] cin_data = '0, cout_data, exit_code;
  logic cout_valid, exit_req;

  int n_checks = 0, n_fail = 0;
  logic [63:0] m_to, m_fh;
  logic [15:0] m_pend;
  bit m_allow;

  always #(CLK_PERIOD/2) clk = ~clk;

  hml_mailbox #(.ADDR_W(12), .TO_OFS(32'h040), .FH_OFS(32'h020)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cin_valid(cin_valid),
    .cin_data(cin_data), .cout_valid(cout_valid), .cout_data(cout_data),
    .exit_req(exit_req), .exit_code(exit_code)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act_v, input logic [63:0] exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act_v, exp_v);
    end
  endtask

  task automatic read_all(input string rq);
    logic [63:0] to_r, fh_r;
    bus_addr = TO_LO; #1; to_r[31:0]  = bus_rdata;
    bus_addr = TO_HI; #1; to_r[63:32] = bus_rdata;
    bus_addr = FH_LO; #1; fh_r[31:0]  = bus_rdata;
    bus_addr = FH_HI; #1; fh_r[63:32] = bus_rdata;
    chk(to_r == m_to, rq, "tohost", to_r, m_to);
    chk(fh_r == m_fh, rq, "fromhost", fh_r, m_fh);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_wr_en = 1'b0; cin_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    m_to = '0; m_fh = '0; m_pend = '0; m_allow = 1'b0;
  endtask

  // One bus/console cycle, modelled from the requirements, then checked.
  task automatic step(input bit we, input logic [11:0] a, input logic [31:0] d,
                      input bit cv, input logic [7:0] cd, input string rq);
    logic [63:0] full;
    logic [15:0] pend_old;
    bit e_put = 0, e_exit = 0, fh_hit = 0;
    logic [7:0] e_pb = '0, e_code = '0;
    pend_old = m_pend;
    if (we) begin
      if (a == TO_LO) begin
        if (m_to == '0) begin m_to = {32'h0, d}; m_allow = 1'b1; end
        else m_allow = 1'b0;
      end else if (a == TO_HI) begin
        if (m_allow) begin
          full = m_to | {d, 32'h0};
          m_to = '0;
          if (full[63:48] == 16'h0100) m_pend = full[63:48];
          else begin
            fh_hit = 1;
            if (full[63:48] == 16'h0000) begin
              m_fh = {full[63:48], 48'h0};
              e_exit = full[0]; e_code = full[8:1];
            end else if (full[63:48] == 16'h0101) begin
              m_fh = {full[63:48], 32'h0, 8'h01, full[7:0]};
              e_put = 1; e_pb = full[7:0];
            end else m_fh = {full[63:48], 48'h0};
          end
        end
      end else if (a == FH_LO) begin m_fh = {32'h0, d}; fh_hit = 1; end
      else if (a == FH_HI) begin m_fh = m_fh | {d, 32'h0}; fh_hit = 1; end
    end
    if (cv && !fh_hit) m_fh = {pend_old, 32'h0, 8'h01, cd};
    @(negedge clk);
    bus_wr_en = we; bus_addr = a; bus_wdata = d; cin_valid = cv; cin_data = cd;
    @(posedge clk); #1;
    bus_wr_en = 1'b0; cin_valid = 1'b0;
    chk(cout_valid == e_put && (!e_put || cout_data == e_pb), rq, "cout",
        {cout_valid, cout_data}, {e_put, e_pb});
    chk(exit_req == e_exit && (!e_exit || exit_code == e_code), rq, "exit",
        {exit_req, exit_code}, {e_exit, e_code});
    read_all(rq);
  endtask

  task automatic send_cmd(input logic [31:0] hi, input logic [31:0] lo, input string rq);
    step(1, TO_LO, lo, 0, 8'h0, rq);
    step(1, TO_HI, hi, 0, 8'h0, rq);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    do_reset();
    // R1 reset state
    #1;
    chk(!cout_valid && !exit_req, "R1", "pulses", {cout_valid, exit_req}, 0);
    read_all("R1");
    // R2, R12 fromhost word access, unmapped address
    step(1, FH_LO, 32'hAABB_CCDD, 0, 0, "R12");
    step(1, FH_HI, 32'h1122_3344, 0, 0, "R2");
    bus_addr = 12'h100; #1;
    chk(bus_rdata == 0, "R2", "unmapped read", bus_rdata, 0);
    step(1, 12'h100, 32'hFFFF_FFFF, 0, 0, "R2");
    step(1, FH_LO, 32'h0000_0055, 0, 0, "R12");
    // R6 exit, code uses payload bit 8
    send_cmd(32'h0000_0000, 32'h0000_01B5, "R6");
    // R7 no exit when payload bit 0 clear
    step(1, FH_LO, 32'hDEAD_BEEF, 0, 0, "R7");
    send_cmd(32'h0000_0000, 32'h0000_0002, "R7");
    // R8, R5 putc with upper payload bits ignored
    send_cmd(32'h0101_ABCD, 32'h9876_5441, "R8");
    // R11 unknown device and code
    send_cmd(32'h0503_0000, 32'h0000_1234, "R11");
    // R9, R10 console read then input bytes
    step(1, FH_LO, 32'h0000_0777, 0, 0, "R9");
    send_cmd(32'h0100_0000, 32'h0000_0000, "R9");
    step(0, 12'h0, 0, 1, 8'h7A, "R10");
    step(0, 12'h0, 0, 1, 8'h33, "R10");
    // R13 collisions
    step(1, FH_LO, 32'h0000_1111, 1, 8'h44, "R13");
    step(1, TO_LO, 32'h0000_0042, 0, 0, "R13");
    step(1, TO_HI, 32'h0101_0000, 1, 8'h55, "R13");
    // R3 rejected low write, then dropped high write
    step(1, TO_LO, 32'h0000_0005, 0, 0, "R3");
    step(1, TO_LO, 32'h0000_0007, 0, 0, "R3");
    step(1, TO_HI, 32'h0101_0000, 0, 0, "R3");
    do_reset();
    read_all("R1");
    // R4 second high write after consume uses zero low word
    send_cmd(32'h0101_0000, 32'h0000_0061, "R4");
    step(1, TO_HI, 32'h0101_0000, 0, 0, "R4");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [31:0] hi, lo;
      op = $urandom % 8;
      hi = {8'($urandom % 3), 8'($urandom % 3), 16'($urandom)};
      lo = $urandom;
      case (op)
        0, 1: step(1, TO_LO, lo, $urandom % 2, 8'($urandom), "R3");
        2, 3: step(1, TO_HI, hi, $urandom % 2, 8'($urandom), "R4");
        4:    step(1, ($urandom % 2) ? FH_LO : FH_HI, lo, $urandom % 2, 8'($urandom), "R12");
        5:    step(0, 12'h0, 0, 1, 8'($urandom), "R10");
        6:    send_cmd(hi, lo, "R5");
        default: step(1, 12'h3F0, lo, 0, 0, "R2");
      endcase
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule